// File: doc/BRIEF.md
# Masked debug breakpoint comparator

This block watches a processor's local data bus and its instruction fetch address, and flags debug breakpoint matches. Software loads four 32-bit registers through a small write port: a data breakpoint value, a data mask, a PC breakpoint value and a PC mask. A mask bit of 1 removes that bit from the compare.

On a valid bus data cycle, the access size and the two low address bits pick the byte lanes that hold the operand, so misaligned byte and word references are supported. The operand is right-justified, masked and compared with the low bits of the breakpoint value. On a valid fetch, the masked program counter is compared with the PC breakpoint. Each hit comes out as a registered pulse on the clock after the qualifying cycle. A separate enable input gates each compare. Trigger sequencing and halting the processor belong to the logic that consumes these pulses.

Top module: `dbg_brk_cmp`

## Requirements
- R1: After reset all four registers are zero and both hit outputs are low.
- R2: A write with `reg_we` high loads `reg_wdata` into the register chosen by `reg_sel` (00 data value, 01 data mask, 10 PC value, 11 PC mask). The new value governs bus cycles from the next clock onward.
- R3: A mask bit of 1 excludes that bit from the compare. A mask bit of 0 makes the bit take part.
- R4: For a byte access (`bus_size`=00), `bus_addr_lo` values 00, 01, 10 and 11 take the operand from data bits 31:24, 23:16, 15:8 and 7:0 respectively.
- R5: For a word access (`bus_size`=01), `bus_addr_lo[1]`=0 takes bits 31:16 and `bus_addr_lo[1]`=1 takes bits 15:0. `bus_addr_lo[0]` has no effect.
- R6: For a longword access (`bus_size`=10), all 32 data bits are compared, whatever the value of `bus_addr_lo`.
- R7: A byte or word operand is right-justified and compared against the low 8 or 16 bits of the data value and mask registers. The upper register bits have no effect.
- R8: The reserved size code 11 never produces a data hit.
- R9: On a valid fetch, the PC compare hits when `fetch_pc` equals the PC value register in every bit that the PC mask leaves clear.
- R10: No data hit occurs unless both `bus_valid` and `data_cmp_en` are high. No PC hit occurs unless both `fetch_valid` and `pc_cmp_en` are high.
- R11: `data_hit` and `pc_hit` are registered. Each one goes high on the clock edge that samples a qualifying cycle, and it lasts one cycle unless the next cycle also qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for the write |
| reg_wdata | input | 32 | Register write data |
| data_cmp_en | input | 1 | Enables the data compare |
| pc_cmp_en | input | 1 | Enables the PC compare |
| bus_valid | input | 1 | A bus data cycle is present |
| bus_size | input | 2 | Access size: 00 byte, 01 word, 10 longword, 11 reserved |
| bus_addr_lo | input | 2 | Low two address bits of the access |
| bus_data | input | 32 | Local data bus |
| fetch_valid | input | 1 | An instruction fetch is present |
| fetch_pc | input | 32 | Program counter of the fetch |
| data_hit | output | 1 | Registered data breakpoint pulse |
| pc_hit | output | 1 | Registered PC breakpoint pulse |

## Verification
The bench sweeps every size code and every low address pair against several data patterns. It plants the operand in the lane it expects, then flips a single unmasked bit, so a swapped lane order or a wrong word half misses the planted match or reports a false hit. Breakpoint values are chosen with non-zero upper bits, so a design that does not right-justify the operand, or that compares the full 32 bits for narrow accesses, loses its byte and word hits. Further checks toggle `bus_addr_lo[0]` on word accesses, use size 11, drop each enable and each valid, and write a register just before a bus cycle. These catch a design that reads A0 for words, hits on the reserved code, ignores the gating, or compares against a stale register.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

    localparam int BUS_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES = BUS_W / LANE_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        SEL_DVAL  = 2'b00,
        SEL_DMASK = 2'b01,
        SEL_PVAL  = 2'b10,
        SEL_PMASK = 2'b11
    } reg_sel_e;

    typedef struct packed {
        logic [BUS_W-1:0] dval;
        logic [BUS_W-1:0] dmask;
        logic [BUS_W-1:0] pval;
        logic [BUS_W-1:0] pmask;
    } brk_regs_t;

    typedef struct packed {
        logic data_hit;
        logic pc_hit;
    } hit_t;

endpackage

// File: rtl/dbg_brk_regs.sv
module dbg_brk_regs
    import dbg_brk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [BUS_W-1:0] wdata,
    output brk_regs_t        regs
);

    brk_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            case (reg_sel_e'(sel))
                SEL_DVAL:  regs_d.dval  = wdata;
                SEL_DMASK: regs_d.dmask = wdata;
                SEL_PVAL:  regs_d.pval  = wdata;
                default:   regs_d.pmask = wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    assign regs = regs_q;

    // R2: a data value write lands in the register on the next edge
    a_r2_dval_write: assert property (@(posedge clk) disable iff (rst)
        (we && sel == 2'b00) |=> (regs.dval == $past(wdata)));

endmodule

// File: rtl/dbg_lane_extract.sv
module dbg_lane_extract
    import dbg_brk_pkg::*;
(
    input  logic [BUS_W-1:0] data,
    input  logic [1:0]       size,
    input  logic [1:0]       addr_lo,
    output logic [BUS_W-1:0] operand,
    output logic [BUS_W-1:0] width_mask,
    output logic             size_ok
);

    localparam int HALF_W = BUS_W / 2;

    // lane 0 is the most significant byte of the bus
    logic [LANES-1:0][LANE_W-1:0] lane_b;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_b[g] = data[BUS_W-1-g*LANE_W -: LANE_W];
    end

    always_comb begin
        operand    = '0;
        width_mask = '0;
        size_ok    = 1'b1;
        case (acc_size_e'(size))
            SZ_BYTE: begin
                operand    = BUS_W'(lane_b[addr_lo]);
                width_mask = BUS_W'({LANE_W{1'b1}});
            end
            SZ_WORD: begin
                operand    = addr_lo[1] ? BUS_W'(data[HALF_W-1:0])
                                        : BUS_W'(data[BUS_W-1:HALF_W]);
                width_mask = BUS_W'({HALF_W{1'b1}});
            end
            SZ_LONG: begin
                operand    = data;
                width_mask = '1;
            end
            default: size_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbg_mask_cmp.sv
module dbg_mask_cmp #(
    parameter int W = 32
) (
    input  logic [W-1:0] value,
    input  logic [W-1:0] ref_val,
    input  logic [W-1:0] ignore,
    output logic         match
);

    assign match = ~|((value ^ ref_val) & ~ignore);

endmodule

// File: rtl/dbg_brk_cmp.sv
module dbg_brk_cmp
    import dbg_brk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic        data_cmp_en,
    input  logic        pc_cmp_en,
    input  logic        bus_valid,
    input  logic [1:0]  bus_size,
    input  logic [1:0]  bus_addr_lo,
    input  logic [31:0] bus_data,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_pc,
    output logic        data_hit,
    output logic        pc_hit
);

    brk_regs_t        regs;
    logic [BUS_W-1:0] operand, width_mask;
    logic             size_ok;
    logic             data_match, pc_match;
    hit_t             hit_d, hit_q;

    dbg_brk_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .regs  (regs)
    );

    dbg_lane_extract u_extract (
        .data       (bus_data),
        .size       (bus_size),
        .addr_lo    (bus_addr_lo),
        .operand    (operand),
        .width_mask (width_mask),
        .size_ok    (size_ok)
    );

    // Bits above the operand width are forced to "ignore".
    dbg_mask_cmp #(.W(BUS_W)) u_data_cmp (
        .value   (operand),
        .ref_val (regs.dval),
        .ignore  (regs.dmask | ~width_mask),
        .match   (data_match)
    );

    dbg_mask_cmp #(.W(BUS_W)) u_pc_cmp (
        .value   (fetch_pc),
        .ref_val (regs.pval),
        .ignore  (regs.pmask),
        .match   (pc_match)
    );

    always_comb begin
        hit_d          = '0;
        hit_d.data_hit = bus_valid && data_cmp_en && size_ok && data_match;
        hit_d.pc_hit   = fetch_valid && pc_cmp_en && pc_match;
    end

    always_ff @(posedge clk) begin
        if (rst) hit_q <= '0;
        else     hit_q <= hit_d;
    end

    assign data_hit = hit_q.data_hit;
    assign pc_hit   = hit_q.pc_hit;

    // R8: the reserved size code never yields a data hit
    a_r8_rsvd_no_hit: assert property (@(posedge clk) disable iff (rst)
        data_hit |-> $past(bus_size) != 2'b11);

    // R10: a data hit needs a valid, enabled bus cycle in the previous cycle
    a_r10_data_gate: assert property (@(posedge clk) disable iff (rst)
        data_hit |-> $past(bus_valid && data_cmp_en));

    // R10: a PC hit needs a valid, enabled fetch in the previous cycle
    a_r10_pc_gate: assert property (@(posedge clk) disable iff (rst)
        pc_hit |-> $past(fetch_valid && pc_cmp_en));

    // R11: with no bus cycle, a data pulse falls on the next edge
    a_r11_data_pulse: assert property (@(posedge clk) disable iff (rst)
        (data_hit && !bus_valid) |=> !data_hit);

endmodule

// File: tb/dbg_brk_cmp_tb.sv
module dbg_brk_cmp_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [1:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic        data_cmp_en, pc_cmp_en;
    logic        bus_valid;
    logic [1:0]  bus_size, bus_addr_lo;
    logic [31:0] bus_data;
    logic        fetch_valid;
    logic [31:0] fetch_pc;
    logic        data_hit, pc_hit;

    int checks = 0;
    int failures = 0;

    logic [31:0] m_dval, m_dmask, m_pval, m_pmask;

    always #2 clk = ~clk;

    dbg_brk_cmp u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .data_cmp_en(data_cmp_en), .pc_cmp_en(pc_cmp_en),
        .bus_valid(bus_valid), .bus_size(bus_size), .bus_addr_lo(bus_addr_lo),
        .bus_data(bus_data), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .data_hit(data_hit), .pc_hit(pc_hit)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        case (sel)
            2'b00: m_dval = v;
            2'b01: m_dmask = v;
            2'b10: m_pval = v;
            default: m_pmask = v;
        endcase
    endtask

    function automatic logic exp_data(input logic [1:0] sz, input logic [1:0] a,
                                      input logic [31:0] d);
        int sh;
        logic [31:0] wm;
        if (sz == 2'b00) begin sh = (3 - int'(a)) * 8; wm = 32'hFF; end
        else if (sz == 2'b01) begin sh = a[1] ? 0 : 16; wm = 32'hFFFF; end
        else if (sz == 2'b10) begin sh = 0; wm = 32'hFFFF_FFFF; end
        else return 1'b0;
        return (((d >> sh) ^ m_dval) & ~m_dmask & wm) == 32'h0;
    endfunction

    function automatic logic [31:0] plant(input logic [1:0] sz, input logic [1:0] a,
                                          input logic [31:0] junk);
        int sh;
        logic [31:0] wm;
        if (sz == 2'b00) begin sh = (3 - int'(a)) * 8; wm = 32'hFF; end
        else if (sz == 2'b01) begin sh = a[1] ? 0 : 16; wm = 32'hFFFF; end
        else begin sh = 0; wm = 32'hFFFF_FFFF; end
        return (junk & ~(wm << sh)) | ((m_dval & wm) << sh);
    endfunction

    // one bus cycle; hit is checked one edge later, then its fall
    task automatic bus(input logic [1:0] sz, input logic [1:0] a, input logic [31:0] d,
                       input logic exp, input string req);
        @(negedge clk);
        bus_valid = 1'b1; bus_size = sz; bus_addr_lo = a; bus_data = d;
        @(negedge clk);
        bus_valid = 1'b0;
        check(data_hit, exp, req);
        @(negedge clk);
        check(data_hit, 1'b0, "R11 pulse ends");
    endtask

    task automatic fetch(input logic [31:0] pc, input logic exp, input string req);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_pc = pc;
        @(negedge clk);
        fetch_valid = 1'b0;
        check(pc_hit, exp, req);
        @(negedge clk);
        check(pc_hit, 1'b0, "R11 pc pulse ends");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] junk [4];
        logic [31:0] dv [3];
        logic [31:0] dm [3];
        junk[0] = 32'hDEAD_BEEF; junk[1] = 32'h0000_0000;
        junk[2] = 32'hFFFF_FFFF; junk[3] = 32'h5A3C_96E1;
        dv[0] = 32'h1234_5678; dv[1] = 32'hCAFE_00A5; dv[2] = 32'h8000_0001;
        dm[0] = 32'h0;         dm[1] = 32'h0F0F_0F0F; dm[2] = 32'hFFFF_FF7E;

        rst = 1'b1; reg_we = 0; reg_sel = 0; reg_wdata = 0;
        data_cmp_en = 0; pc_cmp_en = 0; bus_valid = 0; bus_size = 0;
        bus_addr_lo = 0; bus_data = 0; fetch_valid = 0; fetch_pc = 0;
        m_dval = 0; m_dmask = 0; m_pval = 0; m_pmask = 0;
        repeat (3) @(negedge clk);
        check(data_hit, 1'b0, "R1 data_hit reset");
        check(pc_hit, 1'b0, "R1 pc_hit reset");
        rst = 1'b0;

        // R1: zero registers match zero operands
        data_cmp_en = 1; pc_cmp_en = 1;
        fetch(32'h0, 1'b1, "R1 zero PC regs");
        fetch(32'h4, 1'b0, "R1 zero PC mask");
        bus(2'b10, 2'b00, 32'h0, 1'b1, "R1 zero data regs");

        // R10 gating
        data_cmp_en = 0; pc_cmp_en = 0;
        bus(2'b10, 2'b00, 32'h0, 1'b0, "R10 data disabled");
        fetch(32'h0, 1'b0, "R10 pc disabled");
        data_cmp_en = 1; pc_cmp_en = 1;
        @(negedge clk);
        bus_valid = 0; bus_data = 0; bus_size = 2'b10;
        @(negedge clk);
        check(data_hit, 1'b0, "R10 no valid");

        // sweep R3 R4 R5 R6 R7 R8
        for (int v = 0; v < 3; v++) begin
            for (int mk = 0; mk < 3; mk++) begin
                wr(2'b00, dv[v]);
                wr(2'b01, dm[mk]);
                for (int sz = 0; sz < 4; sz++) begin
                    for (int a = 0; a < 4; a++) begin
                        for (int j = 0; j < 4; j++) begin
                            logic [31:0] d;
                            d = plant(2'(sz), 2'(a), junk[j]);
                            bus(2'(sz), 2'(a), d, exp_data(2'(sz), 2'(a), d),
                                "R4 R5 R6 R7 R8 planted");
                            d = d ^ (32'h1 << ((a * 8 + j * 5) % 32));
                            bus(2'(sz), 2'(a), d, exp_data(2'(sz), 2'(a), d),
                                "R3 R4 R5 R6 R7 flipped");
                            bus(2'(sz), 2'(a), junk[j], exp_data(2'(sz), 2'(a), junk[j]),
                                "R3 R4 R5 R6 junk");
                        end
                    end
                end
            end
        end

        // R5: A0 ignored for words; R7: upper bits ignored
        wr(2'b00, 32'hFFFF_BEEF); wr(2'b01, 32'h0);
        bus(2'b01, 2'b00, 32'hBEEF_0000, 1'b1, "R5 word A=00");
        bus(2'b01, 2'b01, 32'hBEEF_0000, 1'b1, "R5 word A=01 A0 ignored");
        bus(2'b01, 2'b11, 32'h0000_BEEF, 1'b1, "R5 word A=11 A0 ignored");
        bus(2'b01, 2'b10, 32'hBEEF_0000, 1'b0, "R5 word wrong half");
        bus(2'b11, 2'b00, 32'hBEEF_BEEF, 1'b0, "R8 reserved size");
        // R6: longword ignores address
        wr(2'b00, 32'hA1B2_C3D4);
        for (int a = 0; a < 4; a++)
            bus(2'b10, 2'(a), 32'hA1B2_C3D4, 1'b1, "R6 longword any A");

        // R2: write just before a bus cycle takes effect
        wr(2'b00, 32'h0000_0042);
        bus(2'b00, 2'b11, 32'h0000_0042, 1'b1, "R2 new value used");
        wr(2'b01, 32'h0000_00FF);
        bus(2'b00, 2'b11, 32'h0000_0099, 1'b1, "R2 R3 mask written");

        // R9: PC compare with mask
        wr(2'b10, 32'h0001_2340); wr(2'b11, 32'h0000_000F);
        fetch(32'h0001_2340, 1'b1, "R9 exact");
        fetch(32'h0001_234C, 1'b1, "R9 masked low bits");
        fetch(32'h0001_2350, 1'b0, "R9 unmasked bit");
        fetch(32'h8001_2340, 1'b0, "R9 high bit");
        wr(2'b11, 32'hFFFF_FFFF);
        fetch(32'h7777_7777, 1'b1, "R9 R3 all masked");

        // R11: back-to-back qualifying cycles hold the pulse
        @(negedge clk);
        fetch_valid = 1; fetch_pc = 32'h1;
        @(negedge clk);
        check(pc_hit, 1'b1, "R11 first");
        @(negedge clk);
        fetch_valid = 0;
        check(pc_hit, 1'b1, "R11 second");
        @(negedge clk);
        check(pc_hit, 1'b0, "R11 drop");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule